// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer

This block generates a periodic interrupt from a slow time base. The host supplies a single-cycle strobe at the 32.768 kHz base rate, synchronous to the system clock. A prescaler divides that strobe by a power of two chosen in the control register, and each divided pulse decrements a down-counter. When a pulse arrives while the counter holds 1, the counter reloads from the reload register and keeps running. At the same moment it raises a pending flag, which drives a level interrupt until software clears it.

Software reaches the block through a small word-addressed register port. Writes take effect on the next clock edge, and read data is combinational from the address. The address map is fixed: 0 is control, 1 is reload, 2 is live count (read only), and 3 is pending. Control bit 0 is the master enable, bits [7:4] select the divider exponent N, and bit 8 is the tick enable. The counter starts only when a control write raises the tick enable.

Top module: `tick_timer`

## Requirements
- R1: While running, the down-counter steps once for every 2^N base strobes, where N is control bits [7:4]. The first step comes on the 2^N-th strobe after start.
- R2: A control write starts the counter only if its bit 8 is 1 while the stored bit 8 is 0, its bit 0 is 1, and the reload value is nonzero. Starting loads the reload value into the count. Any other control write never starts the counter.
- R3: A control write with bit 0 = 1 and bit 8 = 0, made while the stored bit 8 is 1, stops the counter. The count then stays frozen.
- R4: A write of 2 or less to the reload register (address 1) is ignored and the old value is kept. Larger values are stored.
- R5: A step taken while the count is 1 reloads the count and sets the pending flag (address 3 bit 0). The counter keeps running, so after P steps from a reload value R the count is R − (P mod R).
- R6: Writing 1 to bit 0 at address 3 clears the pending flag, and a write of 0 leaves it set. The `tick_irq` output is high exactly while the flag is set.
- R7: A control write that takes bit 0 from 1 to 0 stops the counter.
- R8: Address 2 reads the live counter value.
- R9: After reset, every register reads zero, `tick_irq` is low and the counter is stopped.
- R10: A control write that changes bits [7:4] restarts the prescaler from zero, so the next step needs a full 2^N strobes at the new setting.
- R11: Control reads return bits 0, [7:4] and 8 as stored and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle strobe at the 32.768 kHz base rate |
| bus_addr | input | 2 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| tick_irq | output | 1 | Level interrupt, high while the pending flag is set |

## Verification
The main function is tried with several pairs of divider exponent and reload value, each followed by a chosen number of base strobes. Short runs check the plain decrement. Runs that end exactly on a reload check the wrap and the flag. Longer runs, whose strobe count is not a multiple of 2^N, show whether the divider drops the partial period. Further directed sequences separate the ways a counter can be stopped or refused a start: tick enable cleared, master cleared, a level write with no edge, and a zero reload. They also check writes to the pending flag with data 0 and data 1. A divider change made in the middle of a period shows whether the prescaler really restarts.

// File: rtl/tick_pkg.sv
package tick_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_PEND   = 2'd3
    } reg_sel_e;

    localparam int CTRL_MASTER_BIT = 0;
    localparam int CTRL_SEL_LSB    = 4;
    localparam int CTRL_TICK_BIT   = 8;
    localparam int RELOAD_MIN_OK   = 3;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             base_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask  = ({{(PRE_W-1){1'b0}}, 1'b1} << sel) - 1'b1;
        tick  = !clear && base_tick && ((cnt_q & mask) == mask);
        cnt_d = cnt_q;
        if (clear)          cnt_d = '0;
        else if (base_tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> base_tick); // R1
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/tick_downcounter.sv
module tick_downcounter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
    } dc_state_t;

    dc_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = st_q.running && step && (st_q.count == CNT_W'(1));
        if (start) begin
            st_d.count   = reload;
            st_d.running = 1'b1;
        end else if (stop) begin
            st_d.running = 1'b0;
        end else if (st_q.running && step) begin
            st_d.count = expire ? reload : st_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.count;
    assign running = st_q.running;

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (count != '0)); // R2
    AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> $stable(count)); // R3
    AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start && !stop) |=> (running && count == $past(reload))); // R5
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);
    import tick_pkg::*;

    typedef struct packed {
        logic             master;
        logic             tick_en;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] reload;
        logic             pending;
    } regs_t;

    regs_t r_d, r_q;

    logic             wr_ctrl, new_master, new_tick;
    logic [SEL_W-1:0] new_sel;
    logic             start, stop, presc_clear;
    logic             step, expire, running;
    logic [CNT_W-1:0] count;

    always_comb begin
        wr_ctrl    = bus_we && (bus_addr == REG_CTRL);
        new_master = bus_wdata[CTRL_MASTER_BIT];
        new_tick   = bus_wdata[CTRL_TICK_BIT];
        new_sel    = bus_wdata[CTRL_SEL_LSB +: SEL_W];

        start = wr_ctrl && new_master && new_tick && !r_q.tick_en
                && (r_q.reload != '0);
        stop  = wr_ctrl && ((r_q.master && !new_master)
                || (new_master && !new_tick && r_q.tick_en));
        presc_clear = !running || start || (wr_ctrl && (new_sel != r_q.sel));

        r_d = r_q;
        if (wr_ctrl) begin
            r_d.master  = new_master;
            r_d.tick_en = new_tick;
            r_d.sel     = new_sel;
        end
        if (bus_we && (bus_addr == REG_RELOAD)
            && (bus_wdata >= DATA_W'(RELOAD_MIN_OK)))
            r_d.reload = bus_wdata[CNT_W-1:0];
        if (expire)
            r_d.pending = 1'b1;
        else if (bus_we && (bus_addr == REG_PEND) && bus_wdata[0])
            r_d.pending = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTRL_MASTER_BIT]            = r_q.master;
                bus_rdata[CTRL_TICK_BIT]              = r_q.tick_en;
                bus_rdata[CTRL_SEL_LSB +: SEL_W]      = r_q.sel;
            end
            REG_RELOAD: bus_rdata[CNT_W-1:0] = r_q.reload;
            REG_COUNT:  bus_rdata[CNT_W-1:0] = count;
            default:    bus_rdata[0]         = r_q.pending;
        endcase
    end

    assign tick_irq = r_q.pending;

    tick_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (presc_clear),
        .base_tick (base_tick),
        .sel       (r_q.sel),
        .tick      (step)
    );

    tick_downcounter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .stop    (stop),
        .step    (step),
        .reload  (r_q.reload),
        .count   (count),
        .running (running),
        .expire  (expire)
    );

    AST_RUN_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (r_q.master && r_q.tick_en)); // R2
    AST_SMALL_RELOAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_RELOAD && bus_wdata < DATA_W'(RELOAD_MIN_OK))
        |=> $stable(r_q.reload)); // R4
    AST_MASTER_FALL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && r_q.master && !new_master) |=> !running); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_PEND && bus_wdata[0] && !expire) |=> !tick_irq); // R6
    AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> tick_irq); // R5
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tick_irq(tick_irq)
    );

    typedef struct packed {
        logic [3:0]  sel;
        logic [15:0] reload;
        logic [7:0]  nbase;
        logic [15:0] exp_cnt;
        logic        exp_pend;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd0, 16'd5,  8'd3,  16'd2,  1'b0},
        '{4'd0, 16'd5,  8'd5,  16'd5,  1'b1},
        '{4'd1, 16'd3,  8'd7,  16'd3,  1'b1},
        '{4'd2, 16'd4,  8'd9,  16'd2,  1'b0},
        '{4'd3, 16'd3,  8'd40, 16'd1,  1'b1},
        '{4'd0, 16'd10, 8'd0,  16'd10, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) base_tick = 1'b1;
            @(negedge clk) base_tick = 1'b0;
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd(2'd0, v); check("R9 ctrl", v, 0);
        rd(2'd1, v); check("R9 reload", v, 0);
        rd(2'd2, v); check("R9 count", v, 0);
        rd(2'd3, v); check("R9 pending", v, 0);
        check("R9 irq", {31'b0, tick_irq}, 0);

        // R2 zero reload refuses start
        wr(2'd0, 32'h101); pulses(4);
        rd(2'd2, v); check("R2 zero reload no start", v, 0);
        wr(2'd0, 32'h0);

        // R4 small reload ignored
        wr(2'd1, 32'd7); wr(2'd1, 32'd2);
        rd(2'd1, v); check("R4 write 2 ignored", v, 7);
        wr(2'd1, 32'd0);
        rd(2'd1, v); check("R4 write 0 ignored", v, 7);
        wr(2'd1, 32'd3);
        rd(2'd1, v); check("R4 write 3 stored", v, 3);

        // R11 control readback
        wr(2'd0, 32'hFFFF_FEF0);
        rd(2'd0, v); check("R11 ctrl bits", v, 32'h0F0);
        wr(2'd0, 32'h0);

        // R2 tick enable without master, then level write with no edge
        wr(2'd0, 32'h100); pulses(5);
        rd(2'd2, v); check("R2 master off", v, 0);
        wr(2'd0, 32'h101); pulses(2);
        rd(2'd2, v); check("R2 no edge", v, 0);
        wr(2'd0, 32'h001);

        // R1 R5 R8 table of divider/reload/strobe runs
        for (int k = 0; k < 6; k++) begin
            wr(2'd0, 32'h001);
            wr(2'd3, 32'h1);
            wr(2'd1, {16'd0, VECS[k].reload});
            wr(2'd0, 32'h101 | ({28'd0, VECS[k].sel} << 4));
            pulses(int'(VECS[k].nbase));
            rd(2'd2, v); check("R1 R8 count", v, {16'd0, VECS[k].exp_cnt});
            check("R5 irq", {31'b0, tick_irq}, {31'b0, VECS[k].exp_pend});
        end

        // R3 tick enable cleared stops and freezes
        wr(2'd0, 32'h001); wr(2'd3, 32'h1); wr(2'd1, 32'd6);
        wr(2'd0, 32'h101);
        rd(2'd2, v); check("R2 start loads", v, 6);
        pulses(2);
        rd(2'd2, v); check("R8 live count", v, 4);
        wr(2'd0, 32'h001); pulses(3);
        rd(2'd2, v); check("R3 frozen", v, 4);

        // R7 master fall stops
        wr(2'd0, 32'h101); pulses(1);
        rd(2'd2, v); check("R7 before", v, 5);
        wr(2'd0, 32'h100); pulses(3);
        rd(2'd2, v); check("R7 stopped", v, 5);

        // R5 R6 expiry and write-one-to-clear
        wr(2'd0, 32'h001); wr(2'd0, 32'h101); pulses(6);
        rd(2'd2, v); check("R5 reload after expiry", v, 6);
        check("R5 irq set", {31'b0, tick_irq}, 1);
        wr(2'd3, 32'h0);
        check("R6 write 0 keeps irq", {31'b0, tick_irq}, 1);
        rd(2'd3, v); check("R6 pending kept", v, 1);
        wr(2'd3, 32'h1);
        check("R6 irq cleared", {31'b0, tick_irq}, 0);
        rd(2'd3, v); check("R6 pending cleared", v, 0);

        // R10 divider change restarts prescaler
        wr(2'd0, 32'h001); wr(2'd0, 32'h121); pulses(3);
        rd(2'd2, v); check("R1 partial period", v, 6);
        wr(2'd0, 32'h111); pulses(1);
        rd(2'd2, v); check("R10 no short pulse", v, 6);
        pulses(1);
        rd(2'd2, v); check("R10 full period", v, 5);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule